// File: doc/BRIEF.md
# Indexed configuration register port

This block is the byte-wide configuration register file of a disk-interface controller, together with the host I/O decoding that reaches it. Three independent access paths lead to the same registers. The first is an index/data pair on the local bus. The second is a 32-bit address latch with a four-byte data window. The third is a window enabled by one byte, which maps the whole register space onto a contiguous I/O range. Host software probes each path in turn. It identifies the device by four fixed identification bytes and confirms it with a scratch-register write/read test. It then programs the control, timing and burst bytes through whichever path answered.

The local-bus base address comes from a strap input. The configuration/revision byte reports which base was chosen, so software can tell the two placements apart. Every access the block claims raises `io_hit` in the same cycle, and read data is returned combinationally.

Top module: `cfg_index_port`

## Requirements
- R1: After a synchronous active-low reset, the local-bus index, the 32-bit address latch, the window-enable byte and every writable register are 0x00.
- R2: Offsets 0x00..0x03 read 0x95, 0x10, 0x40, 0x06 in that order, and writes to them have no effect.
- R3: Offset 0x50 is read-only. Its bits [1:0] hold the revision parameter (default 2, never 0), its bit 5 equals `strap_alt_base`, and all other bits read 0.
- R4: With `strap_alt_base`=0 the local-bus index port is 0x178 and the data port is 0x17C; with 1 they are 0x78 and 0x7C. A byte write to the index port sets the index, a byte read of it returns the index, and a byte access at the data port reaches the register selected by the index. The unselected base pair does not respond. With no access in progress, `io_hit` and `io_rdata` are 0.
- R5: A 32-bit write to 0xCF8 loads the address latch, and a 32-bit read of 0xCF8 returns it. When latch bits [31:8] equal the device key (default 0x800008), a byte access at 0xCFC+n reaches offset {latch[7:2], n}. With any other key, the data window does not respond and ignores writes.
- R6: A byte write of 0x10 to 0xCF8 opens the mapped window, and any other value closes it. A byte read of 0xCF8 returns the enable byte. While the window is open, byte address 0xC000+r reaches offset r; while it is closed, that range does not respond.
- R7: Offset 0x5B is a read/write scratch byte, so a value written there, such as 0xBD, reads back unchanged.
- R8: Offsets 0x51..0x59 are read/write bytes, including the burst byte at 0x59, which holds 0x40 after it is written.
- R9: A 32-bit write to any data window (0xCFC, the mapped window, the local-bus data port) changes no register and is not claimed.
- R10: Offsets that are not implemented (0x04..0x4F, 0x5A, 0x5C..0xFF) read 0x00, and writes to them are ignored.
- R11: All three paths reach one shared register file, so a byte written through one path reads back through the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_alt_base | input | 1 | 1 selects local-bus base 0x78, 0 selects 0x178 |
| io_rd | input | 1 | Host I/O read strobe for this cycle |
| io_wr | input | 1 | Host I/O write strobe for this cycle |
| io_dword | input | 1 | 1 = 32-bit access, 0 = byte access |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 32 | Write data; byte accesses use bits [7:0] |
| io_rdata | output | 32 | Read data, combinational; 0 when not claimed |
| io_hit | output | 1 | The access is claimed by this block |

## Verification
On every cycle, the assertions check the register file's view of each access. Identification and revision bytes must read their fixed values, unimplemented offsets must read zero, and no 32-bit write may reach a register. A closed mapped window must never claim an access, and a scratch write followed at once by a read must return the written byte. The bench scenarios cover what needs a sequence of host operations: that writes through one path appear through the others, that a latch carrying another device's key shuts the data window, that the strap moves the local-bus ports, and that reset clears the latches and writable bytes.

// File: rtl/cfg_port_pkg.sv
// Shared types and constants for the indexed configuration register port.
// Assumes a 16-bit host I/O address space and byte-wide registers.
package cfg_port_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;

    // Result of one access path's decoding for the current cycle.
    typedef struct packed {
        logic                hit;       // path claims the access
        logic                req;       // access targets the register file
        logic [BYTE_W-1:0]   off;       // register offset for req
        logic                own;       // read of the path's own latch
        logic [WORD_W-1:0]   own_data;  // value of that latch
    } path_out_t;

endpackage

// File: rtl/cfg_lb_path.sv
// Local-bus index/data access path.
// A byte write to the index port selects a register; byte accesses at
// index port + 4 move data. The base is chosen by a strap between two
// parameters. 32-bit accesses are not claimed.
module cfg_lb_path
    import cfg_port_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_MAIN = 16'h0178,
    parameter logic [15:0] BASE_ALT  = 16'h0078,
    parameter int          DATA_GAP  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_alt,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              io_dword,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [BYTE_W-1:0] io_wdata,
    output path_out_t         po
);

    localparam logic [ADDR_W-1:0] MAIN_IDX = ADDR_W'(BASE_MAIN);
    localparam logic [ADDR_W-1:0] ALT_IDX  = ADDR_W'(BASE_ALT);
    localparam logic [ADDR_W-1:0] GAP      = ADDR_W'(DATA_GAP);

    logic [BYTE_W-1:0] index_q;
    logic [ADDR_W-1:0] idx_port;
    logic              access;
    logic              idx_sel;
    logic              dat_sel;

    // Select the strapped base and decode the two byte ports.
    always_comb begin
        idx_port = strap_alt ? ALT_IDX : MAIN_IDX;
        access   = (io_rd || io_wr) && !io_dword;
        idx_sel  = access && (io_addr == idx_port);
        dat_sel  = access && (io_addr == idx_port + GAP);
    end

    // Index latch: loaded by a byte write to the index port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            index_q <= '0;
        else if (io_wr && idx_sel)
            index_q <= io_wdata;
    end

    // Present this path's decode result.
    always_comb begin
        po.hit      = idx_sel || dat_sel;
        po.req      = dat_sel;
        po.off      = index_q;
        po.own      = io_rd && idx_sel;
        po.own_data = {{(WORD_W-BYTE_W){1'b0}}, index_q};
    end

endmodule

// File: rtl/cfg_t1_path.sv
// Latched-address access path: a 32-bit address latch at one port and a
// four-byte data window beside it. The window answers only while the
// latch carries this device's key in bits [31:8]. The dword-aligned
// offset in the latch is combined with the byte lane of the data address.
module cfg_t1_path
    import cfg_port_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [31:0] DEV_KEY    = 32'h8000_0800,
    parameter logic [15:0] LATCH_PORT = 16'h0CF8,
    parameter logic [15:0] DATA_PORT  = 16'h0CFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              io_dword,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [WORD_W-1:0] io_wdata,
    output path_out_t         po
);

    localparam int                  LANE_W  = 2;
    localparam logic [ADDR_W-1:0]   L_PORT  = ADDR_W'(LATCH_PORT);
    localparam logic [ADDR_W-LANE_W-1:0] D_WORD = DATA_PORT[ADDR_W-1:LANE_W];
    localparam logic [WORD_W-BYTE_W-1:0] KEY_HI = DEV_KEY[WORD_W-1:BYTE_W];

    logic [WORD_W-1:0] latch_q;
    logic              latch_sel;
    logic              key_ok;
    logic              win_sel;

    // Decode the latch port and the keyed data window.
    always_comb begin
        latch_sel = (io_rd || io_wr) && io_dword && (io_addr == L_PORT);
        key_ok    = (latch_q[WORD_W-1:BYTE_W] == KEY_HI);
        win_sel   = (io_rd || io_wr) && !io_dword && key_ok &&
                    (io_addr[ADDR_W-1:LANE_W] == D_WORD);
    end

    // Address latch: loaded by a 32-bit write to the latch port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (io_wr && latch_sel)
            latch_q <= io_wdata;
    end

    // Present this path's decode result.
    always_comb begin
        po.hit      = latch_sel || win_sel;
        po.req      = win_sel;
        po.off      = {latch_q[BYTE_W-1:LANE_W], io_addr[LANE_W-1:0]};
        po.own      = io_rd && latch_sel;
        po.own_data = latch_q;
    end

endmodule

// File: rtl/cfg_t2_path.sv
// Mapped-window access path: a byte written to the enable port opens or
// closes a 256-byte window at a key address; offset r sits at key + r.
// Assumes the key is 256-byte aligned. Only byte accesses are claimed.
module cfg_t2_path
    import cfg_port_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] WIN_KEY   = 16'hC000,
    parameter logic [15:0] EN_PORT   = 16'h0CF8,
    parameter logic [7:0]  OPEN_CODE = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              io_dword,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [BYTE_W-1:0] io_wdata,
    output path_out_t         po,
    output logic              win_open
);

    localparam logic [ADDR_W-1:0]        E_PORT = ADDR_W'(EN_PORT);
    localparam logic [ADDR_W-BYTE_W-1:0] K_HI   = WIN_KEY[ADDR_W-1:BYTE_W];

    logic [BYTE_W-1:0] enable_q;
    logic              access;
    logic              en_sel;
    logic              win_sel;

    // Decode the enable port and the mapped window.
    always_comb begin
        access   = (io_rd || io_wr) && !io_dword;
        win_open = (enable_q == OPEN_CODE);
        en_sel   = access && (io_addr == E_PORT);
        win_sel  = access && win_open && (io_addr[ADDR_W-1:BYTE_W] == K_HI);
    end

    // Enable byte: loaded by a byte write to the enable port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (io_wr && en_sel)
            enable_q <= io_wdata;
    end

    // Present this path's decode result.
    always_comb begin
        po.hit      = en_sel || win_sel;
        po.req      = win_sel;
        po.off      = io_addr[BYTE_W-1:0];
        po.own      = io_rd && en_sel;
        po.own_data = {{(WORD_W-BYTE_W){1'b0}}, enable_q};
    end

endmodule

// File: rtl/cfg_regfile.sv
// Byte-wide configuration register file shared by all access paths.
// Fixed identification bytes at the bottom, a read-only revision/status
// byte, a contiguous run of writable bytes with one hole, zeros elsewhere.
// Assumes at most one register access per cycle.
module cfg_regfile
    import cfg_port_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1095,
    parameter logic [15:0] DEVICE_ID  = 16'h0640,
    parameter int          REVISION   = 2,
    parameter int          STATUS_OFF = 8'h50,
    parameter int          BASE_BIT   = 5,
    parameter int          RW_FIRST   = 8'h51,
    parameter int          RW_LAST    = 8'h5B,
    parameter int          HOLE_OFF   = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_alt,
    input  logic              we,
    input  logic [BYTE_W-1:0] off,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);

    localparam int                RW_SPAN = RW_LAST - RW_FIRST + 1;
    localparam int                IDX_W   = $clog2(RW_SPAN);
    localparam int                ID_BYTES = 4;
    localparam logic [31:0]       ID_WORD = {DEVICE_ID, VENDOR_ID};
    localparam logic [BYTE_W-1:0] REV_BITS = BYTE_W'(REVISION & 3);

    logic [BYTE_W-1:0] slot_q [RW_SPAN];
    logic [RW_SPAN-1:0] slot_we;
    logic [BYTE_W-1:0] rel;

    // Per-slot write enables; the hole never gets one.
    for (genvar g = 0; g < RW_SPAN; g++) begin : g_slot
        localparam int SLOT_OFF = RW_FIRST + g;
        if (SLOT_OFF == HOLE_OFF) begin : g_hole
            assign slot_we[g] = 1'b0;
        end else begin : g_live
            assign slot_we[g] = we && (off == BYTE_W'(SLOT_OFF));
        end
    end

    // Writable bytes: cleared by reset, loaded by their own enable.
    always_ff @(posedge clk) begin
        for (int i = 0; i < RW_SPAN; i++) begin
            if (!rst_n)
                slot_q[i] <= '0;
            else if (slot_we[i])
                slot_q[i] <= wdata;
        end
    end

    // Read multiplexer over the fixed, status and writable regions.
    always_comb begin
        rel   = off - BYTE_W'(RW_FIRST);
        rdata = '0;
        if (off < BYTE_W'(ID_BYTES))
            rdata = ID_WORD[BYTE_W*off[1:0] +: BYTE_W];
        else if (off == BYTE_W'(STATUS_OFF))
            rdata = REV_BITS | (BYTE_W'(strap_alt) << BASE_BIT);
        else if (off >= BYTE_W'(RW_FIRST) && off <= BYTE_W'(RW_LAST))
            rdata = slot_q[rel[IDX_W-1:0]];
    end

endmodule

// File: rtl/cfg_index_port.sv
// Indexed configuration register port: three host access paths in front
// of one register file. Assumes the paths' port ranges do not overlap,
// so at most one path claims any access.
module cfg_index_port
    import cfg_port_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] LB_MAIN   = 16'h0178,
    parameter logic [15:0] LB_ALT    = 16'h0078,
    parameter logic [31:0] T1_KEY    = 32'h8000_0800,
    parameter logic [15:0] T2_KEY    = 16'hC000,
    parameter logic [15:0] CFG_PORT  = 16'h0CF8,
    parameter logic [15:0] DATA_PORT = 16'h0CFC,
    parameter logic [15:0] VENDOR_ID = 16'h1095,
    parameter logic [15:0] DEVICE_ID = 16'h0640,
    parameter int          REVISION  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_alt_base,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              io_dword,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [31:0]       io_wdata,
    output logic [31:0]       io_rdata,
    output logic              io_hit
);

    localparam int N_PATH = 3;

    path_out_t         pth [N_PATH];
    logic              t2_open;
    logic              rf_req;
    logic              rf_we;
    logic [BYTE_W-1:0] rf_off;
    logic [BYTE_W-1:0] rf_rdata;

    cfg_lb_path #(
        .ADDR_W(ADDR_W), .BASE_MAIN(LB_MAIN), .BASE_ALT(LB_ALT)
    ) i_lb (
        .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt_base),
        .io_rd(io_rd), .io_wr(io_wr), .io_dword(io_dword),
        .io_addr(io_addr), .io_wdata(io_wdata[BYTE_W-1:0]), .po(pth[0])
    );

    cfg_t1_path #(
        .ADDR_W(ADDR_W), .DEV_KEY(T1_KEY),
        .LATCH_PORT(CFG_PORT), .DATA_PORT(DATA_PORT)
    ) i_t1 (
        .clk(clk), .rst_n(rst_n),
        .io_rd(io_rd), .io_wr(io_wr), .io_dword(io_dword),
        .io_addr(io_addr), .io_wdata(io_wdata), .po(pth[1])
    );

    cfg_t2_path #(
        .ADDR_W(ADDR_W), .WIN_KEY(T2_KEY), .EN_PORT(CFG_PORT)
    ) i_t2 (
        .clk(clk), .rst_n(rst_n),
        .io_rd(io_rd), .io_wr(io_wr), .io_dword(io_dword),
        .io_addr(io_addr), .io_wdata(io_wdata[BYTE_W-1:0]),
        .po(pth[2]), .win_open(t2_open)
    );

    // Merge the path requests into one register-file access.
    always_comb begin
        rf_req = 1'b0;
        rf_off = '0;
        for (int p = N_PATH - 1; p >= 0; p--) begin
            if (pth[p].req) begin
                rf_req = 1'b1;
                rf_off = pth[p].off;
            end
        end
        rf_we = rf_req && io_wr;
    end

    cfg_regfile #(
        .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REVISION(REVISION)
    ) i_rf (
        .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt_base),
        .we(rf_we), .off(rf_off), .wdata(io_wdata[BYTE_W-1:0]),
        .rdata(rf_rdata)
    );

    // Claim flag and read data returned to the host.
    always_comb begin
        io_hit   = 1'b0;
        io_rdata = '0;
        for (int p = 0; p < N_PATH; p++) begin
            io_hit = io_hit || pth[p].hit;
            if (pth[p].own)
                io_rdata = pth[p].own_data;
        end
        if (io_rd && rf_req)
            io_rdata = {24'h0, rf_rdata};
    end

endmodule

// File: rtl/cfg_index_port_chk.sv
// Checker for cfg_index_port, bound to every instance of it. It watches
// the host ports and the merged register-file request.
module cfg_index_port_chk #(
    parameter logic [15:0] VENDOR_ID = 16'h1095,
    parameter logic [15:0] DEVICE_ID = 16'h0640,
    parameter int          REVISION  = 2,
    parameter logic [15:0] T2_KEY    = 16'hC000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        strap_alt_base,
    input logic        io_rd,
    input logic        io_wr,
    input logic        io_dword,
    input logic [15:0] io_addr,
    input logic [31:0] io_wdata,
    input logic [31:0] io_rdata,
    input logic        io_hit,
    input logic        rf_req,
    input logic        rf_we,
    input logic [7:0]  rf_off,
    input logic [7:0]  rf_rdata,
    input logic        t2_open
);

    logic [31:0] id_word;
    logic [7:0]  id_exp;
    logic [7:0]  stat_exp;
    logic        unimpl;

    // Expected values from the requirements.
    always_comb begin
        id_word  = {DEVICE_ID, VENDOR_ID};
        id_exp   = id_word[8*rf_off[1:0] +: 8];
        stat_exp = 8'(REVISION & 3) | {2'b00, strap_alt_base, 5'b00000};
        unimpl   = (rf_off >= 8'h04 && rf_off < 8'h50) || (rf_off == 8'h5A) ||
                   (rf_off > 8'h5B);
    end

    assert_id_bytes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && rf_off < 8'h04) |-> (rf_rdata == id_exp));

    assert_status_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && rf_off == 8'h50) |-> (rf_rdata == stat_exp));

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd || io_wr) |-> (!io_hit && io_rdata == 32'h0));

    assert_closed_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!t2_open && io_addr[15:8] == T2_KEY[15:8]) |-> !io_hit);

    assert_scratch_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && !rf_we && rf_off == 8'h5B && $past(rst_n) &&
         $past(rf_we && rf_off == 8'h5B)) |-> (rf_rdata == $past(io_wdata[7:0])));

    assert_no_wide_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_dword) |-> !rf_we);

    assert_unimpl_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && unimpl) |-> (rf_rdata == 8'h00));

endmodule

bind cfg_index_port cfg_index_port_chk #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
    .REVISION(REVISION), .T2_KEY(T2_KEY)
) i_chk (
    .clk(clk), .rst_n(rst_n), .strap_alt_base(strap_alt_base),
    .io_rd(io_rd), .io_wr(io_wr), .io_dword(io_dword),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_hit(io_hit), .rf_req(rf_req), .rf_we(rf_we), .rf_off(rf_off),
    .rf_rdata(rf_rdata), .t2_open(t2_open)
);

// File: tb/test_cfg_index_port.sv
// Bench for cfg_index_port: a vector table walked by one loop, then
// directed reset and strap tests.
module test_cfg_index_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_alt_base = 1'b0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic        io_dword = 1'b0;
    logic [15:0] io_addr = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        io_hit;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cfg_index_port i_cfg_index_port (
        .clk(clk), .rst_n(rst_n), .strap_alt_base(strap_alt_base),
        .io_rd(io_rd), .io_wr(io_wr), .io_dword(io_dword),
        .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_hit(io_hit)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        rd;
        logic        dw;
        logic [15:0] addr;
        logic [31:0] dat;
        logic        hit;
    } vec_t;

    localparam int NV = 61;
    localparam vec_t TBL [NV] = '{
        '{4'd4,  1'b0, 1'b0, 16'h0178, 32'h00, 1'b1},  // R4 index 0
        '{4'd2,  1'b1, 1'b0, 16'h017C, 32'h95, 1'b1},  // R2
        '{4'd4,  1'b0, 1'b0, 16'h0178, 32'h01, 1'b1},
        '{4'd2,  1'b1, 1'b0, 16'h017C, 32'h10, 1'b1},
        '{4'd4,  1'b0, 1'b0, 16'h0178, 32'h03, 1'b1},
        '{4'd2,  1'b1, 1'b0, 16'h017C, 32'h06, 1'b1},
        '{4'd2,  1'b0, 1'b0, 16'h017C, 32'hAA, 1'b1},  // R2 write ignored
        '{4'd2,  1'b1, 1'b0, 16'h017C, 32'h06, 1'b1},
        '{4'd4,  1'b0, 1'b0, 16'h0178, 32'h50, 1'b1},
        '{4'd3,  1'b1, 1'b0, 16'h017C, 32'h02, 1'b1},  // R3
        '{4'd3,  1'b0, 1'b0, 16'h017C, 32'hFF, 1'b1},
        '{4'd3,  1'b1, 1'b0, 16'h017C, 32'h02, 1'b1},  // R3 read-only
        '{4'd4,  1'b0, 1'b0, 16'h0178, 32'h5B, 1'b1},
        '{4'd7,  1'b0, 1'b0, 16'h017C, 32'hBD, 1'b1},  // R7
        '{4'd7,  1'b1, 1'b0, 16'h017C, 32'hBD, 1'b1},
        '{4'd4,  1'b0, 1'b0, 16'h0178, 32'h59, 1'b1},
        '{4'd8,  1'b0, 1'b0, 16'h017C, 32'h40, 1'b1},  // R8 burst
        '{4'd8,  1'b1, 1'b0, 16'h017C, 32'h40, 1'b1},
        '{4'd4,  1'b1, 1'b0, 16'h0178, 32'h59, 1'b1},  // R4 index readback
        '{4'd4,  1'b1, 1'b0, 16'h007C, 32'h00, 1'b0},  // R4 other base
        '{4'd5,  1'b0, 1'b1, 16'h0CF8, 32'h80000858, 1'b1},  // R5
        '{4'd5,  1'b1, 1'b1, 16'h0CF8, 32'h80000858, 1'b1},
        '{4'd11, 1'b1, 1'b0, 16'h0CFD, 32'h40, 1'b1},  // R11
        '{4'd11, 1'b1, 1'b0, 16'h0CFF, 32'hBD, 1'b1},
        '{4'd5,  1'b0, 1'b0, 16'h0CFC, 32'h33, 1'b1},
        '{4'd9,  1'b0, 1'b1, 16'h0CFC, 32'hFFFFFFFF, 1'b0},  // R9
        '{4'd9,  1'b1, 1'b0, 16'h0CFC, 32'h33, 1'b1},
        '{4'd9,  1'b1, 1'b0, 16'h0CFD, 32'h40, 1'b1},
        '{4'd9,  1'b1, 1'b0, 16'h0CFF, 32'hBD, 1'b1},
        '{4'd5,  1'b0, 1'b1, 16'h0CF8, 32'h80000850, 1'b1},
        '{4'd3,  1'b1, 1'b0, 16'h0CFC, 32'h02, 1'b1},
        '{4'd5,  1'b0, 1'b1, 16'h0CF8, 32'h80001050, 1'b1},  // R5 other key
        '{4'd5,  1'b1, 1'b0, 16'h0CFC, 32'h00, 1'b0},
        '{4'd5,  1'b0, 1'b0, 16'h0CFC, 32'h77, 1'b0},
        '{4'd5,  1'b0, 1'b1, 16'h0CF8, 32'h80000858, 1'b1},
        '{4'd5,  1'b1, 1'b0, 16'h0CFC, 32'h33, 1'b1},
        '{4'd6,  1'b1, 1'b0, 16'hC059, 32'h00, 1'b0},  // R6 closed
        '{4'd6,  1'b0, 1'b0, 16'h0CF8, 32'h10, 1'b1},
        '{4'd6,  1'b1, 1'b0, 16'h0CF8, 32'h10, 1'b1},
        '{4'd5,  1'b1, 1'b1, 16'h0CF8, 32'h80000858, 1'b1},
        '{4'd11, 1'b1, 1'b0, 16'hC059, 32'h40, 1'b1},
        '{4'd7,  1'b0, 1'b0, 16'hC05B, 32'h5A, 1'b1},
        '{4'd7,  1'b1, 1'b0, 16'hC05B, 32'h5A, 1'b1},
        '{4'd2,  1'b1, 1'b0, 16'hC001, 32'h10, 1'b1},
        '{4'd9,  1'b0, 1'b1, 16'hC052, 32'h12345678, 1'b0},
        '{4'd9,  1'b1, 1'b0, 16'hC052, 32'h00, 1'b1},
        '{4'd10, 1'b0, 1'b0, 16'hC05A, 32'hEE, 1'b1},  // R10
        '{4'd10, 1'b1, 1'b0, 16'hC05A, 32'h00, 1'b1},
        '{4'd10, 1'b1, 1'b0, 16'hC060, 32'h00, 1'b1},
        '{4'd10, 1'b0, 1'b0, 16'hC010, 32'hEE, 1'b1},
        '{4'd10, 1'b1, 1'b0, 16'hC010, 32'h00, 1'b1},
        '{4'd6,  1'b0, 1'b0, 16'h0CF8, 32'h00, 1'b1},
        '{4'd6,  1'b1, 1'b0, 16'hC059, 32'h00, 1'b0},
        '{4'd4,  1'b0, 1'b0, 16'h0178, 32'h5B, 1'b1},
        '{4'd11, 1'b1, 1'b0, 16'h017C, 32'h5A, 1'b1},
        '{4'd4,  1'b0, 1'b0, 16'h0178, 32'h58, 1'b1},
        '{4'd11, 1'b0, 1'b0, 16'h017C, 32'h21, 1'b1},
        '{4'd11, 1'b1, 1'b0, 16'h0CFC, 32'h21, 1'b1},
        '{4'd4,  1'b0, 1'b0, 16'h0178, 32'h52, 1'b1},
        '{4'd8,  1'b0, 1'b0, 16'h017C, 32'h3C, 1'b1},
        '{4'd8,  1'b1, 1'b0, 16'h017C, 32'h3C, 1'b1}
    };

    // One host access: drive at the falling edge, compare just after,
    // let the rising edge commit any write.
    task automatic do_op(input int req, input bit rd, input bit dw,
                         input logic [15:0] addr, input logic [31:0] dat,
                         input bit hit);
        @(negedge clk);
        io_rd    = rd;
        io_wr    = !rd;
        io_dword = dw;
        io_addr  = addr;
        io_wdata = rd ? 32'h0 : dat;
        #1;
        n_cmp++;
        if (io_hit !== hit || (rd && io_rdata !== dat)) begin
            n_bad++;
            $display("FAIL R%0d addr=%h hit=%b data=%h expected hit=%b data=%h",
                     req, addr, io_hit, io_rdata, hit, rd ? dat : io_rdata);
        end
        @(posedge clk);
        #1;
        io_rd = 1'b0;
        io_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state through the ports
        do_op(1, 1, 1, 16'h0CF8, 32'h0, 1);
        do_op(1, 1, 0, 16'h0CF8, 32'h0, 1);
        do_op(1, 1, 0, 16'h0178, 32'h0, 1);
        for (int i = 0; i < NV; i++)
            do_op(int'(TBL[i].req), TBL[i].rd, TBL[i].dw, TBL[i].addr,
                  TBL[i].dat, TBL[i].hit);
        // R4 idle cycle: nothing claimed, data zero
        @(negedge clk);
        #1;
        n_cmp++;
        if (io_hit !== 1'b0 || io_rdata !== 32'h0) begin
            n_bad++;
            $display("FAIL R4 idle hit=%b data=%h expected hit=0 data=0", io_hit, io_rdata);
        end
        // R1 second reset clears latches and writable bytes
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        do_op(1, 1, 1, 16'h0CF8, 32'h0, 1);
        do_op(1, 1, 0, 16'h0CF8, 32'h0, 1);
        do_op(1, 1, 0, 16'h0178, 32'h0, 1);
        do_op(1, 0, 0, 16'h0178, 32'h5B, 1);
        do_op(1, 1, 0, 16'h017C, 32'h0, 1);
        do_op(1, 0, 0, 16'h0178, 32'h59, 1);
        do_op(1, 1, 0, 16'h017C, 32'h0, 1);
        // R3 and R4 with the alternate strap
        @(negedge clk);
        strap_alt_base = 1'b1;
        do_op(4, 0, 0, 16'h0078, 32'h50, 1);
        do_op(3, 1, 0, 16'h007C, 32'h22, 1);
        do_op(4, 1, 0, 16'h017C, 32'h0, 0);
        do_op(4, 1, 0, 16'h0078, 32'h50, 1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule